// File: doc/BRIEF.md
# Miss status holding register file

This block keeps a small, fixed set of entries that each track one outstanding cache line miss. A new miss claims the lowest-numbered free entry. The entry records the line address, a ready time, a stamp from a global allocation counter, whether the access was uncacheable, and an allocate-on-fill decision. Later requests to the same line merge into that entry as extra targets. The allocate-on-fill decision is sticky: a merged request can turn it on but never turns it off. A parallel address lookup tells the surrounding cache controller whether a line already has an entry, and which one. A release returns the entry to the free pool once its fill has completed.

Each entry runs a small state machine. From ENT_FREE, an accepted allocate moves it to ENT_PEND (waiting, not yet issued). From ENT_PEND, an issue mark moves it to ENT_SVC (request in service). From ENT_PEND or ENT_SVC, a release moves it back to ENT_FREE. On each cycle the file acts on at most one operation, chosen by an operation selector with the states OP_IDLE, OP_RELEASE, OP_ALLOC, OP_MERGE and OP_ISSUE, in that order of precedence.

Two blocking outputs are separate: one for "every entry is in use" and one for "some entry's target list is full". An operation that is illegal in the current state leaves all state unchanged and raises a one-cycle error flag.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free, full_o, notgt_o and err_o are low, and the allocation stamp counter is zero.
- R2: An accepted allocate takes the lowest-indexed free entry, shown beforehand on alloc_idx_o (0 when none is free). It stores the address, ready time, uncacheable bit and fill flag, and a stamp equal to the counter value, then increments the counter (8 bits, wrapping). The entry starts in ENT_PEND with a target count of 1.
- R3: An accepted merge adds one to the entry's target count and sets its fill flag to the OR of the old flag and merge_fill_i. This is allowed in ENT_PEND and in ENT_SVC.
- R4: notgt_o is high exactly while some in-use entry holds MAX_TGT targets.
- R5: full_o is high exactly while all entries are in use.
- R6: A merge aimed at a free entry, or at an entry allocated as uncacheable, is rejected.
- R7: lkp_hit_o is high when an in-use entry's line address (the address above the low LINE_OFF bits, so the offset bits are ignored) equals that of lkp_addr_i; lkp_idx_o gives that entry, or 0 on a miss.
- R8: An allocate is rejected while full_o is high, when the low LINE_OFF address bits are not zero, or when the line already has an entry. A merge is rejected while notgt_o is high. A rejected operation changes no state (the stamp counter included), and err_o is high in the cycle after it.
- R9: An accepted release frees the entry and clears its target count and fill flag. A release of a free entry is rejected with err_o.
- R10: An issue mark moves an ENT_PEND entry to ENT_SVC (rd_issued_o high). An issue mark on any other entry is rejected with err_o.
- R11: When several operation strobes are high together, only the first of release, allocate, merge, issue acts. The others are dropped without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Allocate a new entry for a miss |
| alloc_addr_i | input | ADDR_W | Line-aligned miss address |
| alloc_time_i | input | TIME_W | Ready time recorded in the entry |
| alloc_fill_i | input | 1 | Allocate-on-fill decision of the first request |
| alloc_unc_i | input | 1 | Miss is uncacheable |
| merge_i | input | 1 | Merge a request into an entry |
| merge_idx_i | input | IDX_W | Entry that receives the merge |
| merge_fill_i | input | 1 | Allocate-on-fill decision of the merged request |
| issue_i | input | 1 | Mark an entry as in service |
| issue_idx_i | input | IDX_W | Entry to mark |
| release_i | input | 1 | Free an entry after its fill |
| release_idx_i | input | IDX_W | Entry to free |
| lkp_addr_i | input | ADDR_W | Address to look up |
| lkp_hit_o | output | 1 | Lookup found an entry |
| lkp_idx_o | output | IDX_W | Matching entry |
| alloc_idx_o | output | IDX_W | Entry the next allocate will take |
| full_o | output | 1 | All entries in use |
| notgt_o | output | 1 | Some entry's target list is full |
| err_o | output | 1 | Previous cycle's operation was rejected |
| rd_idx_i | input | IDX_W | Entry shown on the read port |
| rd_valid_o | output | 1 | Entry in use |
| rd_addr_o | output | ADDR_W | Stored address |
| rd_time_o | output | TIME_W | Stored ready time |
| rd_order_o | output | ORDER_W | Stored allocation stamp |
| rd_ntgt_o | output | CNT_W | Target count |
| rd_fill_o | output | 1 | Allocate-on-fill flag |
| rd_issued_o | output | 1 | Entry is in service |
| rd_unc_o | output | 1 | Entry is uncacheable |

## Verification
Every operation acts on the clock edge where its strobe is sampled. Entry contents, full_o, notgt_o and err_o therefore show the result right after that edge, with no further delay. Lookup, alloc_idx_o and the read port are combinational views of the registered entries, so they are valid in the same cycle their select inputs are driven. The bench drives inputs 1 ns after a rising edge and updates its behavioural model on that edge. It compares every output against the model at the falling edge, half a period after the update. Directed checks sample 1 ns after the edge that applied the operation.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_PEND = 2'd1,
        ENT_SVC  = 2'd2
    } ent_state_e;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_RELEASE = 3'd1,
        OP_ALLOC   = 3'd2,
        OP_MERGE   = 3'd3,
        OP_ISSUE   = 3'd4
    } op_e;
endpackage

// File: rtl/mshr_slot.sv
module mshr_slot
    import mshr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TIME_W  = 16,
    parameter int ORDER_W = 8,
    parameter int MAX_TGT = 4,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic               merge_en,
    input  logic               issue_en,
    input  logic               free_en,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [TIME_W-1:0]  in_time,
    input  logic [ORDER_W-1:0] in_order,
    input  logic               in_fill,
    input  logic               in_unc,
    input  logic               in_merge_fill,
    output ent_state_e         st_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [TIME_W-1:0]  time_q,
    output logic [ORDER_W-1:0] order_q,
    output logic [CNT_W-1:0]   ntgt_q,
    output logic               fill_q,
    output logic               unc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ENT_FREE;
            addr_q  <= '0;
            time_q  <= '0;
            order_q <= '0;
            ntgt_q  <= '0;
            fill_q  <= 1'b0;
            unc_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ENT_FREE: begin
                    if (alloc_en) begin
                        st_q    <= ENT_PEND;
                        addr_q  <= in_addr;
                        time_q  <= in_time;
                        order_q <= in_order;
                        ntgt_q  <= CNT_W'(1);
                        fill_q  <= in_fill;
                        unc_q   <= in_unc;
                    end
                end
                ENT_PEND, ENT_SVC: begin
                    if (free_en) begin
                        st_q   <= ENT_FREE;
                        ntgt_q <= '0;
                        fill_q <= 1'b0;
                    end else if (merge_en) begin
                        ntgt_q <= ntgt_q + CNT_W'(1);
                        fill_q <= fill_q | in_merge_fill;
                    end else if (issue_en && st_q == ENT_PEND) begin
                        st_q <= ENT_SVC;
                    end
                end
                default: st_q <= ENT_FREE;
            endcase
        end
    end

    AST_FRESH_ONE_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_PEND && $past(st_q) == ENT_FREE) |-> (ntgt_q == CNT_W'(1))); // R2
    AST_TGT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ntgt_q <= CNT_W'(MAX_TGT)); // R4
    AST_FILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ENT_FREE && fill_q) |=> (st_q == ENT_FREE || fill_q)); // R3

endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (!busy[k]) idx = IDX_W'(k);
        end
    end
    assign any_free = ~&busy;
endmodule

// File: rtl/mshr_cam.sv
module mshr_cam #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 26
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][TAG_W-1:0]   tags,
    input  logic [TAG_W-1:0]          key,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx
);
    logic [N-1:0] match;

    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign match[k] = valid[k] && (tags[k] == key);
    end

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (match[k]) idx = IDX_W'(k);
        end
    end
    assign hit = |match;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R7
endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int N_ENT    = 4,
    parameter int MAX_TGT  = 4,
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 6,
    parameter int TIME_W   = 16,
    parameter int ORDER_W  = 8,
    localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int CNT_W   = $clog2(MAX_TGT + 1),
    localparam int TAG_W   = ADDR_W - LINE_OFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic [ADDR_W-1:0]  alloc_addr_i,
    input  logic [TIME_W-1:0]  alloc_time_i,
    input  logic               alloc_fill_i,
    input  logic               alloc_unc_i,
    input  logic               merge_i,
    input  logic [IDX_W-1:0]   merge_idx_i,
    input  logic               merge_fill_i,
    input  logic               issue_i,
    input  logic [IDX_W-1:0]   issue_idx_i,
    input  logic               release_i,
    input  logic [IDX_W-1:0]   release_idx_i,
    input  logic [ADDR_W-1:0]  lkp_addr_i,
    output logic               lkp_hit_o,
    output logic [IDX_W-1:0]   lkp_idx_o,
    output logic [IDX_W-1:0]   alloc_idx_o,
    output logic               full_o,
    output logic               notgt_o,
    output logic               err_o,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic               rd_valid_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic [TIME_W-1:0]  rd_time_o,
    output logic [ORDER_W-1:0] rd_order_o,
    output logic [CNT_W-1:0]   rd_ntgt_o,
    output logic               rd_fill_o,
    output logic               rd_issued_o,
    output logic               rd_unc_o
);

    ent_state_e                     e_st [N_ENT];
    logic [N_ENT-1:0][ADDR_W-1:0]   e_addr;
    logic [N_ENT-1:0][TIME_W-1:0]   e_time;
    logic [N_ENT-1:0][ORDER_W-1:0]  e_order;
    logic [N_ENT-1:0][CNT_W-1:0]    e_ntgt;
    logic [N_ENT-1:0][TAG_W-1:0]    e_tag;
    logic [N_ENT-1:0]               e_fill, e_unc, valid, at_max;
    logic [N_ENT-1:0]               a_en, m_en, i_en, r_en;

    logic [ORDER_W-1:0] order_q;
    logic               err_q, bad;
    logic               free_any, dup_hit, misalign;
    logic [IDX_W-1:0]   free_idx, dup_idx;
    logic               unused_lsb;
    op_e                op;

    assign unused_lsb = ^{lkp_addr_i[LINE_OFF-1:0], dup_idx, free_any};
    assign misalign   = |alloc_addr_i[LINE_OFF-1:0];

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        assign valid[k]  = (e_st[k] != ENT_FREE);
        assign at_max[k] = valid[k] && (e_ntgt[k] == CNT_W'(MAX_TGT));
        assign e_tag[k]  = e_addr[k][ADDR_W-1:LINE_OFF];

        mshr_slot #(
            .ADDR_W(ADDR_W), .TIME_W(TIME_W), .ORDER_W(ORDER_W),
            .MAX_TGT(MAX_TGT), .CNT_W(CNT_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(a_en[k]), .merge_en(m_en[k]),
            .issue_en(i_en[k]), .free_en(r_en[k]),
            .in_addr(alloc_addr_i), .in_time(alloc_time_i),
            .in_order(order_q), .in_fill(alloc_fill_i),
            .in_unc(alloc_unc_i), .in_merge_fill(merge_fill_i),
            .st_q(e_st[k]), .addr_q(e_addr[k]), .time_q(e_time[k]),
            .order_q(e_order[k]), .ntgt_q(e_ntgt[k]),
            .fill_q(e_fill[k]), .unc_q(e_unc[k])
        );
    end

    mshr_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
        .busy(valid), .any_free(free_any), .idx(free_idx)
    );

    mshr_cam #(.N(N_ENT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_cam_lkp (
        .clk(clk), .rst_n(rst_n), .valid(valid), .tags(e_tag),
        .key(lkp_addr_i[ADDR_W-1:LINE_OFF]), .hit(lkp_hit_o), .idx(lkp_idx_o)
    );

    mshr_cam #(.N(N_ENT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_cam_dup (
        .clk(clk), .rst_n(rst_n), .valid(valid), .tags(e_tag),
        .key(alloc_addr_i[ADDR_W-1:LINE_OFF]), .hit(dup_hit), .idx(dup_idx)
    );

    assign full_o  = &valid;
    assign notgt_o = |at_max;

    // operation selector: fixed precedence
    always_comb begin
        if (release_i)      op = OP_RELEASE;
        else if (alloc_i)   op = OP_ALLOC;
        else if (merge_i)   op = OP_MERGE;
        else if (issue_i)   op = OP_ISSUE;
        else                op = OP_IDLE;
    end

    // per-operation legality and entry enables
    always_comb begin
        a_en = '0;
        m_en = '0;
        i_en = '0;
        r_en = '0;
        bad  = 1'b0;
        unique case (op)
            OP_RELEASE: begin
                if (!valid[release_idx_i]) bad = 1'b1;
                else                       r_en[release_idx_i] = 1'b1;
            end
            OP_ALLOC: begin
                if (full_o || misalign || dup_hit) bad = 1'b1;
                else                               a_en[free_idx] = 1'b1;
            end
            OP_MERGE: begin
                if (notgt_o || !valid[merge_idx_i] || e_unc[merge_idx_i]) bad = 1'b1;
                else                                                      m_en[merge_idx_i] = 1'b1;
            end
            OP_ISSUE: begin
                if (e_st[issue_idx_i] != ENT_PEND) bad = 1'b1;
                else                               i_en[issue_idx_i] = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= bad;
            if (op == OP_ALLOC && !bad) order_q <= order_q + ORDER_W'(1);
        end
    end

    assign err_o       = err_q;
    assign alloc_idx_o = free_idx;
    assign rd_valid_o  = valid[rd_idx_i];
    assign rd_addr_o   = e_addr[rd_idx_i];
    assign rd_time_o   = e_time[rd_idx_i];
    assign rd_order_o  = e_order[rd_idx_i];
    assign rd_ntgt_o   = e_ntgt[rd_idx_i];
    assign rd_fill_o   = e_fill[rd_idx_i];
    assign rd_issued_o = (e_st[rd_idx_i] == ENT_SVC);
    assign rd_unc_o    = e_unc[rd_idx_i];

    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && alloc_i && !release_i) |=> err_o); // R8
    AST_NOTGT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (notgt_o && merge_i && !alloc_i && !release_i) |=> err_o); // R8
    AST_UNC_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_i && !alloc_i && !release_i && e_unc[merge_idx_i]
         && e_st[merge_idx_i] != ENT_FREE) |=> err_o); // R6
    AST_REJECT_KEEPS_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && alloc_i && !release_i) |=> $stable(order_q)); // R8

endmodule

// File: tb/mshr_file_tb_top.sv
`timescale 1ns/1ps
module mshr_file_tb_top;
    localparam int N = 4;
    localparam int MAXT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_i = 0, alloc_fill_i = 0, alloc_unc_i = 0;
    logic [31:0] alloc_addr_i = '0;
    logic [15:0] alloc_time_i = '0;
    logic        merge_i = 0, merge_fill_i = 0;
    logic [1:0]  merge_idx_i = '0;
    logic        issue_i = 0;
    logic [1:0]  issue_idx_i = '0;
    logic        release_i = 0;
    logic [1:0]  release_idx_i = '0;
    logic [31:0] lkp_addr_i = '0;
    logic [1:0]  rd_idx_i = '0;
    logic        lkp_hit_o, full_o, notgt_o, err_o;
    logic [1:0]  lkp_idx_o, alloc_idx_o;
    logic        rd_valid_o, rd_fill_o, rd_issued_o, rd_unc_o;
    logic [31:0] rd_addr_o;
    logic [15:0] rd_time_o;
    logic [7:0]  rd_order_o;
    logic [2:0]  rd_ntgt_o;

    int nchk = 0, nerr = 0;
    bit run = 0;

    always #2 clk = ~clk;

    mshr_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(alloc_i), .alloc_addr_i(alloc_addr_i), .alloc_time_i(alloc_time_i),
        .alloc_fill_i(alloc_fill_i), .alloc_unc_i(alloc_unc_i),
        .merge_i(merge_i), .merge_idx_i(merge_idx_i), .merge_fill_i(merge_fill_i),
        .issue_i(issue_i), .issue_idx_i(issue_idx_i),
        .release_i(release_i), .release_idx_i(release_idx_i),
        .lkp_addr_i(lkp_addr_i), .lkp_hit_o(lkp_hit_o), .lkp_idx_o(lkp_idx_o),
        .alloc_idx_o(alloc_idx_o), .full_o(full_o), .notgt_o(notgt_o), .err_o(err_o),
        .rd_idx_i(rd_idx_i), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
        .rd_time_o(rd_time_o), .rd_order_o(rd_order_o), .rd_ntgt_o(rd_ntgt_o),
        .rd_fill_o(rd_fill_o), .rd_issued_o(rd_issued_o), .rd_unc_o(rd_unc_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int mv[N], ma[N], mt[N], mo[N], mn[N], mf[N], mu[N], ms[N];
    int mord = 0, merr = 0, m_bad, m_j;

    function automatic int m_full();
        for (int k = 0; k < N; k++) if (!mv[k]) return 0;
        return 1;
    endfunction
    function automatic int m_blk();
        for (int k = 0; k < N; k++) if (mv[k] && mn[k] == MAXT) return 1;
        return 0;
    endfunction
    function automatic int m_free();
        for (int k = 0; k < N; k++) if (!mv[k]) return k;
        return -1;
    endfunction
    function automatic int m_find(int a);
        for (int k = 0; k < N; k++) if (mv[k] && (ma[k] >>> 6) == (a >>> 6)) return k;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                mv[k] = 0; ma[k] = 0; mt[k] = 0; mo[k] = 0;
                mn[k] = 0; mf[k] = 0; mu[k] = 0; ms[k] = 0;
            end
            mord = 0; merr = 0;
        end else begin
            m_bad = 0;
            if (release_i) begin
                if (!mv[release_idx_i]) m_bad = 1;
                else begin
                    mv[release_idx_i] = 0; mn[release_idx_i] = 0;
                    mf[release_idx_i] = 0; ms[release_idx_i] = 0;
                end
            end else if (alloc_i) begin
                if (m_full() || (int'(alloc_addr_i) % 64) != 0 || m_find(int'(alloc_addr_i)) >= 0)
                    m_bad = 1;
                else begin
                    m_j = m_free();
                    mv[m_j] = 1; ma[m_j] = int'(alloc_addr_i); mt[m_j] = int'(alloc_time_i);
                    mo[m_j] = mord; mn[m_j] = 1; mf[m_j] = alloc_fill_i;
                    mu[m_j] = alloc_unc_i; ms[m_j] = 0;
                    mord = (mord + 1) % 256;
                end
            end else if (merge_i) begin
                if (m_blk() || !mv[merge_idx_i] || mu[merge_idx_i]) m_bad = 1;
                else begin
                    mn[merge_idx_i] = mn[merge_idx_i] + 1;
                    mf[merge_idx_i] = mf[merge_idx_i] | merge_fill_i;
                end
            end else if (issue_i) begin
                if (!mv[issue_idx_i] || ms[issue_idx_i]) m_bad = 1;
                else ms[issue_idx_i] = 1;
            end
            merr = m_bad;
        end
    end

    int cf, cr;
    always @(negedge clk) begin
        if (rst_n && run) begin
            chk("R5", "full", full_o, m_full());
            chk("R4", "notgt", notgt_o, m_blk());
            chk("R8", "err", err_o, merr);
            cf = m_free();
            chk("R2", "alloc_idx", alloc_idx_o, (cf < 0) ? 0 : cf);
            cf = m_find(int'(lkp_addr_i));
            chk("R7", "lkp_hit", lkp_hit_o, cf >= 0);
            chk("R7", "lkp_idx", lkp_idx_o, (cf < 0) ? 0 : cf);
            cr = rd_idx_i;
            chk("R9", "rd_valid", rd_valid_o, mv[cr]);
            chk("R3", "rd_ntgt", rd_ntgt_o, mn[cr]);
            chk("R3", "rd_fill", rd_fill_o, mf[cr]);
            chk("R10", "rd_issued", rd_issued_o, ms[cr]);
            if (mv[cr]) begin
                chk("R2", "rd_addr", rd_addr_o, ma[cr]);
                chk("R2", "rd_time", rd_time_o, mt[cr]);
                chk("R2", "rd_order", rd_order_o, mo[cr]);
                chk("R6", "rd_unc", rd_unc_o, mu[cr]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        alloc_i = 0; merge_i = 0; issue_i = 0; release_i = 0;
    endtask

    task automatic do_alloc(logic [31:0] a, logic [15:0] t, logic f, logic u);
        alloc_i = 1; alloc_addr_i = a; alloc_time_i = t; alloc_fill_i = f; alloc_unc_i = u;
        tick();
    endtask
    task automatic do_merge(logic [1:0] i, logic f);
        merge_i = 1; merge_idx_i = i; merge_fill_i = f;
        tick();
    endtask
    task automatic do_issue(logic [1:0] i);
        issue_i = 1; issue_idx_i = i;
        tick();
    endtask
    task automatic do_release(logic [1:0] i);
        release_i = 1; release_idx_i = i;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        run = 1;
        // R1 reset state
        chk("R1", "full", full_o, 0);
        chk("R1", "notgt", notgt_o, 0);
        chk("R1", "err", err_o, 0);
        chk("R1", "rd_valid", rd_valid_o, 0);

        rd_idx_i = 0; do_alloc(32'h1000, 16'd5, 0, 0);
        chk("R2", "first stamp", rd_order_o, 0);
        chk("R2", "first count", rd_ntgt_o, 1);
        rd_idx_i = 1; do_alloc(32'h2040, 16'd9, 1, 1);
        chk("R2", "second stamp", rd_order_o, 1);
        chk("R2", "next free", alloc_idx_o, 2);

        rd_idx_i = 0; do_merge(0, 1);
        chk("R3", "fill or", rd_fill_o, 1);
        do_merge(0, 0);
        chk("R3", "fill sticky", rd_fill_o, 1);
        do_merge(0, 0);
        chk("R4", "notgt raised", notgt_o, 1);
        do_merge(0, 1);
        chk("R8", "merge while blocked", err_o, 1);
        chk("R8", "count kept", rd_ntgt_o, MAXT);

        rd_idx_i = 2; lkp_addr_i = 32'h3080; do_alloc(32'h3080, 16'd3, 0, 0);
        chk("R2", "alloc under notgt", err_o, 0);
        chk("R7", "lookup C", lkp_idx_o, 2);
        chk("R2", "third stamp", rd_order_o, 2);

        rd_idx_i = 0; do_release(0);
        chk("R9", "notgt dropped", notgt_o, 0);
        chk("R9", "freed count", rd_ntgt_o, 0);
        rd_idx_i = 1; do_merge(1, 1);
        chk("R6", "uncacheable merge", err_o, 1);
        do_merge(0, 1);
        chk("R6", "merge free", err_o, 1);

        lkp_addr_i = 32'h6000; do_alloc(32'h6004, 16'd1, 0, 0);
        chk("R8", "misaligned", err_o, 1);
        chk("R8", "misaligned no entry", lkp_hit_o, 0);
        do_alloc(32'h2040, 16'd1, 0, 0);
        chk("R8", "duplicate", err_o, 1);

        rd_idx_i = 0; do_alloc(32'h40C0, 16'd7, 0, 0);
        chk("R2", "lowest free reused", rd_valid_o, 1);
        chk("R2", "stamp after rejects", rd_order_o, 3);
        do_alloc(32'h5100, 16'd8, 1, 0);
        chk("R5", "full", full_o, 1);
        do_alloc(32'h7000, 16'd2, 0, 0);
        chk("R8", "alloc while full", err_o, 1);

        lkp_addr_i = 32'h40FF; #1;
        chk("R7", "offset ignored hit", lkp_hit_o, 1);
        chk("R7", "offset ignored idx", lkp_idx_o, 0);
        lkp_addr_i = 32'h2041; #1;
        chk("R7", "lookup B", lkp_idx_o, 1);

        rd_idx_i = 2; do_issue(2);
        chk("R10", "issued", rd_issued_o, 1);
        do_issue(2);
        chk("R10", "issue twice", err_o, 1);
        do_merge(2, 1);
        chk("R3", "merge into issued", rd_ntgt_o, 2);

        lkp_addr_i = 32'h8000;
        release_i = 1; release_idx_i = 3; alloc_i = 1; alloc_addr_i = 32'h8000;
        tick();
        chk("R11", "alloc dropped", lkp_hit_o, 0);
        chk("R11", "no error", err_o, 0);
        chk("R11", "release acted", full_o, 0);
        do_release(3);
        chk("R9", "release free", err_o, 1);
        rd_idx_i = 3; do_alloc(32'h8000, 16'd4, 0, 0);
        chk("R2", "stamp five", rd_order_o, 5);

        for (int i = 0; i < 60; i++) begin
            rd_idx_i = 2'(i % 4);
            lkp_addr_i = 32'(((i * 5) % 12) << 6) | 32'(i % 64);
            case (i % 6)
                0: begin release_i = 1; release_idx_i = 2'(i % 4); end
                1: begin alloc_i = 1; alloc_addr_i = 32'(((i * 7) % 12) << 6);
                         alloc_time_i = 16'(i * 3); alloc_fill_i = 1'(i % 2);
                         alloc_unc_i = (i % 5 == 1); end
                2: begin merge_i = 1; merge_idx_i = 2'((i / 2) % 4); merge_fill_i = (i % 3 == 0); end
                3: begin issue_i = 1; issue_idx_i = 2'(i % 4); end
                4: begin alloc_i = 1; alloc_addr_i = 32'(((i * 11) % 12) << 6);
                         merge_i = 1; merge_idx_i = 2'(i % 4); end
                default: ;
            endcase
            tick();
        end

        @(negedge clk);
        run = 0;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule